// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port

This block is the programming front end for a frequency synthesizer. A serial data line and a serial clock shift configuration bits into one of three shift registers: a primary frequency register, an image register that mirrors the word held in nonvolatile storage, or a small enhancement register. Two control lines choose the target. The serial clock, the strobes and the data line are treated as synchronous to a faster system clock. Their rising edges are found by comparing each line with its value one system clock earlier.

Writing a frequency is double buffered. Bits shift into the primary register while the synthesizer core keeps using the secondary register. A rising edge on the secondary-write strobe then copies the primary word into the secondary register in a single step. A rising edge on the load line copies the externally stored word into the image register. While the load line stays high, each serial clock edge shifts the image register toward bit 0, so its contents come out on the serial output. A frequency-select line chooses whether the core sees the secondary word or the image word. The enhancement bits reach the core only while the active-low enhancement-mode input is low.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, every register is zero, so coreWord, enhBits and serOut all read zero whatever the value of freqSel.
- R2: When eeLoad and enhWr are both low, each serial clock rising edge shifts the primary register right and puts serData into bit 19. After 20 edges, the first bit sent sits in bit 0 (least significant bit first).
- R3: A shift happens only on a low-to-high change of serClk. Holding serClk high for several system clocks gives exactly one shift.
- R4: A rising edge of secWr copies all 20 primary bits into the secondary register in one step. At all other times the secondary register keeps its value, even while the primary register is being shifted.
- R5: When enhWr is high and eeLoad is low, serial clock edges shift the 8-bit enhancement register, least significant bit first, and leave the primary register unchanged.
- R6: enhBits equals the enhancement register while enhModeN is low, and is forced to zero while enhModeN is high.
- R7: A rising edge of eeLoad loads storedWord into the image register. If a serial clock edge arrives in the same cycle, the load wins.
- R8: While eeLoad stays high, each serial clock edge shifts the image register right with serData entering bit 19. serOut always shows bit 0 of the image register, so the stored bits come out in order from bit 0 to bit 19. eeLoad takes priority over enhWr, and the enhancement register does not change.
- R9: coreWord shows the secondary register when freqSel is 1 and the image register when freqSel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; its rising edge shifts one bit |
| serData | input | 1 | Serial data, least significant bit first |
| secWr | input | 1 | Secondary-write strobe; its rising edge copies the primary register to the secondary register |
| enhWr | input | 1 | Selects the enhancement register as the shift target |
| eeLoad | input | 1 | Rising edge loads the image register; while high, selects the image register as the shift and readback target |
| enhModeN | input | 1 | Active-low enable for the enhancement outputs |
| freqSel | input | 1 | 1: core uses the secondary word; 0: core uses the image word |
| storedWord | input | 20 | Word from nonvolatile storage, the parallel source for the image register |
| serOut | output | 1 | Serial readback, bit 0 of the image register |
| coreWord | output | 20 | Frequency word sent to the synthesizer core |
| enhBits | output | 8 | Gated enhancement bits |

## Verification
Asymmetric words are shifted with a one-cycle serial clock, and one word is sent with the clock held high for three cycles. This tells a correct edge detector apart from a level-sensitive shifter. The primary word is checked both before and after the secondary-write strobe, which shows that the double buffering isolates the core. Bits are shifted with enhWr high and the primary word checked afterwards, which separates the enhancement target from the primary target. The image-register load is raised in the same cycle as a serial clock edge. A readback sequence is then run with enhWr also high, which exposes any mistake in the load-versus-shift priority or in the target priority.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int FREQ_BITS = 20;
  localparam int ENH_BITS  = 8;

  typedef struct packed {
    logic shiftPrim;
    logic shiftNv;
    logic shiftEnh;
    logic loadNv;
    logic xferSec;
  } cfg_strobe_t;
endpackage

// File: rtl/cfg_shreg.sv
module cfg_shreg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shiftEn,
  input  logic         loadEn,
  input  logic         serIn,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        q <= '0;
    else if (loadEn)  q <= loadVal;
    else if (shiftEn) q <= {serIn, q[W-1:1]};
  end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        secWr,
  input  logic        eeLoad,
  input  logic        enhWr,
  output cfg_strobe_t strobe
);
  logic serClkQ, secWrQ, eeLoadQ;
  logic clkRise, secRise, loadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      secWrQ  <= 1'b0;
      eeLoadQ <= 1'b0;
    end else begin
      serClkQ <= serClk;
      secWrQ  <= secWr;
      eeLoadQ <= eeLoad;
    end
  end

  assign clkRise  = serClk & ~serClkQ;
  assign secRise  = secWr & ~secWrQ;
  assign loadRise = eeLoad & ~eeLoadQ;

  always_comb begin
    strobe           = '0;
    strobe.xferSec   = secRise;
    strobe.loadNv    = loadRise;
    strobe.shiftNv   = clkRise & eeLoad & ~loadRise;
    strobe.shiftEnh  = clkRise & ~eeLoad & enhWr;
    strobe.shiftPrim = clkRise & ~eeLoad & ~enhWr;
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int FREQ_W = FREQ_BITS,
  parameter int ENH_W  = ENH_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  input  logic              serData,
  input  logic              enhModeN,
  input  logic              freqSel,
  input  logic [FREQ_W-1:0] storedWord,
  output logic              serOut,
  output logic [FREQ_W-1:0] coreWord,
  output logic [ENH_W-1:0]  enhBits,
  output logic [FREQ_W-1:0] primWord,
  output logic [FREQ_W-1:0] secWord,
  output logic [FREQ_W-1:0] nvWord,
  output logic [ENH_W-1:0]  enhWord
);
  cfg_shreg #(.W(FREQ_W)) u_prim (
    .clk(clk), .rstN(rstN), .shiftEn(strobe.shiftPrim), .loadEn(1'b0),
    .serIn(serData), .loadVal('0), .q(primWord));

  cfg_shreg #(.W(FREQ_W)) u_nv (
    .clk(clk), .rstN(rstN), .shiftEn(strobe.shiftNv), .loadEn(strobe.loadNv),
    .serIn(serData), .loadVal(storedWord), .q(nvWord));

  cfg_shreg #(.W(ENH_W)) u_enh (
    .clk(clk), .rstN(rstN), .shiftEn(strobe.shiftEnh), .loadEn(1'b0),
    .serIn(serData), .loadVal('0), .q(enhWord));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               secWord <= '0;
    else if (strobe.xferSec) secWord <= primWord;
  end

  assign serOut   = nvWord[0];
  assign coreWord = freqSel ? secWord : nvWord;

  for (genvar i = 0; i < ENH_W; i++) begin : g_enhGate
    assign enhBits[i] = enhWord[i] & ~enhModeN;
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import cfg_pkg::*;
#(
  parameter int FREQ_W = FREQ_BITS,
  parameter int ENH_W  = ENH_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              secWr,
  input  logic              enhWr,
  input  logic              eeLoad,
  input  logic              enhModeN,
  input  logic              freqSel,
  input  logic [FREQ_W-1:0] storedWord,
  output logic              serOut,
  output logic [FREQ_W-1:0] coreWord,
  output logic [ENH_W-1:0]  enhBits
);
  cfg_strobe_t       strobe;
  logic [FREQ_W-1:0] primWord, secWord, nvWord;
  logic [ENH_W-1:0]  enhWord;

  cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .secWr(secWr),
    .eeLoad(eeLoad), .enhWr(enhWr), .strobe(strobe));

  cfg_datapath #(.FREQ_W(FREQ_W), .ENH_W(ENH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serData(serData),
    .enhModeN(enhModeN), .freqSel(freqSel), .storedWord(storedWord),
    .serOut(serOut), .coreWord(coreWord), .enhBits(enhBits),
    .primWord(primWord), .secWord(secWord), .nvWord(nvWord), .enhWord(enhWord));
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int FW = 20,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          serClk,
  input logic          secWr,
  input logic          eeLoad,
  input logic          enhModeN,
  input logic [EW-1:0] enhBits,
  input logic [FW-1:0] primWord,
  input logic [FW-1:0] secWord,
  input logic [FW-1:0] nvWord,
  input logic [EW-1:0] enhWord
);
  logic clkQ, wrQ, ldQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ <= 1'b0; wrQ <= 1'b0; ldQ <= 1'b0;
    end else begin
      clkQ <= serClk; wrQ <= secWr; ldQ <= eeLoad;
    end
  end

  // R4
  sec_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secWr && !wrQ) |=> secWord == $past(primWord));
  // R4
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(secWr && !wrQ) |=> $stable(secWord));
  // R3
  prim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(serClk && !clkQ) |=> $stable(primWord));
  // R8
  nv_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && !clkQ && eeLoad && ldQ) |=> nvWord[FW-2:0] == $past(nvWord[FW-1:1]));
  // R8
  enh_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeLoad |=> $stable(enhWord));
  // R6
  enh_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    enhModeN |-> enhBits == '0);
endmodule

bind synth_cfg_port cfg_port_chk #(.FW(FREQ_W), .EW(ENH_W)) u_chk (
  .clk(clk), .rstN(rstN), .serClk(serClk), .secWr(secWr), .eeLoad(eeLoad),
  .enhModeN(enhModeN), .enhBits(enhBits), .primWord(primWord),
  .secWord(secWord), .nvWord(nvWord), .enhWord(enhWord));

// File: tb/test_synth_cfg_port.sv
`timescale 1ns/1ps
module test_synth_cfg_port;
  logic clk = 0, rstN = 0;
  logic serClk = 0, serData = 0, secWr = 0, enhWr = 0, eeLoad = 0;
  logic enhModeN = 0, freqSel = 0;
  logic [19:0] storedWord = '0;
  logic serOut;
  logic [19:0] coreWord;
  logic [7:0] enhBits;

  always #2 clk = ~clk;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .secWr(secWr),
    .enhWr(enhWr), .eeLoad(eeLoad), .enhModeN(enhModeN), .freqSel(freqSel),
    .storedWord(storedWord), .serOut(serOut), .coreWord(coreWord), .enhBits(enhBits));

  typedef struct {
    int          kind;   // 0 coreWord, 1 enhBits, 2 serOut
    logic [19:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic expect_item(input int kind, input logic [19:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [19:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = coreWord;
        1:       act = {12'h0, enhBits};
        default: act = {19'h0, serOut};
      endcase
      checks++;
      if (act !== it.val) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic send_bit(input logic b, input int hold);
    @(negedge clk);
    serData = b;
    serClk = 1;
    repeat (hold) @(negedge clk);
    serClk = 0;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [19:0] w, input int n, input int hold);
    for (int i = 0; i < n; i++) send_bit(w[i], hold);
  endtask

  task automatic pulse_sec();
    @(negedge clk); secWr = 1;
    @(negedge clk); secWr = 0;
    @(negedge clk);
  endtask

  localparam logic [19:0] WA = 20'hA5C3E;
  localparam logic [19:0] WB = 20'h1F0B6;
  localparam logic [19:0] WS = 20'h3C5A9;
  localparam logic [19:0] WC = 20'h6E247;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    expect_item(0, 20'h0, "R1 image word");
    expect_item(1, 20'h0, "R1 enh");
    expect_item(2, 20'h0, "R1 serOut");
    freqSel = 1;
    expect_item(0, 20'h0, "R1 secondary word");

    // R2 / R4: shift WA, secondary untouched until strobe
    send_word(WA, 20, 1);
    expect_item(0, 20'h0, "R4 secondary held during shift");
    pulse_sec();
    expect_item(0, WA, "R2 R4 LSB-first word transferred");

    // R3: serial clock held high three cycles per bit
    send_word(WB, 20, 3);
    expect_item(0, WA, "R4 secondary held");
    pulse_sec();
    expect_item(0, WB, "R3 single shift per edge");

    // R5 / R6: enhancement register
    enhWr = 1;
    send_word(20'h00096, 8, 1);
    enhWr = 0;
    expect_item(1, 20'h00096, "R5 R6 enh loaded and visible");
    enhModeN = 1;
    @(negedge clk);
    expect_item(1, 20'h0, "R6 enh gated off");
    enhModeN = 0;
    @(negedge clk);
    pulse_sec();
    expect_item(0, WB, "R5 primary untouched by enh shift");

    // R7: load coincident with serial clock edge, load wins
    storedWord = WS;
    freqSel = 0;
    @(negedge clk);
    eeLoad = 1; serClk = 1; serData = 0;
    @(negedge clk);
    serClk = 0;
    @(negedge clk);
    expect_item(0, WS, "R7 image loaded, load over shift");
    expect_item(2, {19'h0, WS[0]}, "R7 serOut bit0");

    // R8: readback with enhWr also high
    enhWr = 1;
    for (int i = 0; i < 20; i++) begin
      expect_item(2, {19'h0, WS[i]}, "R8 readback bit");
      send_bit(WC[i], 1);
    end
    enhWr = 0;
    expect_item(0, WC, "R8 image shifted in");
    expect_item(1, 20'h00096, "R8 enh untouched under load");
    eeLoad = 0;

    // R9: select
    freqSel = 1;
    @(negedge clk);
    expect_item(0, WB, "R9 select secondary");
    freqSel = 0;
    @(negedge clk);
    expect_item(0, WC, "R9 select image");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule